// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block sits beside a UART datapath. It holds the 8-bit interrupt enable register and reduces every enabled interrupt source to one interrupt line and one 6-bit status code. The code always names the most urgent pending source. Each source has its own latch or level, and each one clears under its own rule. Some sources clear on a register access and some clear when their condition goes away.

Level sources come straight from the datapath: received data, the receive FIFO at or above its trigger, and the transmit empty flags. Event sources arrive as one-cycle pulses: line error changes, modem deltas, flow-control character detection, and RTS or CTS edges. A timer built into the block counts bit-time ticks. When received data sits below the trigger for four character times plus twelve bit times, the timer raises a receive timeout. The upper four enable bits are written and take effect only while the enhanced-function input is high.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, `ier_q` is 0x00, `isr_code` is 0x01 and `irq` is low.
- R2: A write with `ier_wr` always loads `ier_q[3:0]`. It loads `ier_q[7:4]` only while `enh_en` is 1; otherwise those bits keep their value. `sleep_en` equals `ier_q[4]` while `enh_en` is 1 and is 0 otherwise.
- R3: While `enh_en` is 0, enable bits 7:4 have no effect on `isr_code` or `irq`, even if they are set. Events seen meanwhile stay latched and appear once `enh_en` returns to 1.
- R4: With `ier_q[0]` set, code 0x04 reports received data. The condition is `rx_avail` when `fifo_en` is 0, and `rx_at_trig` when `fifo_en` is 1. The code drops as soon as that condition drops.
- R5: In FIFO mode, with `ier_q[0]` set, code 0x0C appears when data is present below the trigger for 4*CHAR_BITS+12 `bit_tick` pulses. With the default CHAR_BITS of 10, that is 52 pulses. Any `rx_char_evt` restarts the count and removes the code.
- R6: With `ier_q[1]` set, a rising edge of the selected empty flag raises code 0x02. The selected flag is `thr_empty` normally and `tsr_empty` when `rs485_auto` is 1. The code clears on a status read that reports 0x02, on `thr_wr`, or when the flag falls.
- R7: With `ier_q[2]` set, an `lsr_err_chg` pulse latches code 0x06. Only `lsr_rd` clears it; a status read does not.
- R8: With `ier_q[3]` set, a pulse on any bit of `msr_chg` latches code 0x00. `msr_rd` clears it.
- R9: Code 0x10 reports `xoff_det` (enable bit 5). Code 0x20 reports `rts_edge` (enable bit 6) or `cts_edge` (enable bit 7). Each clears on a status read that reports it.
- R10: The priority, from highest, is 0x06, 0x0C, 0x04, 0x02, 0x00, 0x10, 0x20. Lower-priority sources stay pending while a higher one is shown.
- R11: With all effective enables at zero (polled mode), `irq` stays low and `isr_code` stays 0x01 whatever the sources do.
- R12: `irq` is high exactly when `isr_code` differs from 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced-function enable, gates bits 7:4 |
| fifo_en | input | 1 | FIFO mode |
| rs485_auto | input | 1 | Auto RS485 mode, selects the transmit source |
| rx_avail | input | 1 | Character held (non-FIFO mode) |
| rx_at_trig | input | 1 | Receive FIFO at or above its trigger |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_char_evt | input | 1 | Character pushed or popped |
| bit_tick | input | 1 | One pulse per bit time |
| thr_empty | input | 1 | Holding register empty / below transmit trigger |
| tsr_empty | input | 1 | Transmitter fully empty |
| thr_wr | input | 1 | Transmit data write |
| lsr_err_chg | input | 1 | Line error bits changed |
| lsr_rd | input | 1 | Line status register read |
| msr_chg | input | 4 | Modem status delta pulses |
| msr_rd | input | 1 | Modem status register read |
| xoff_det | input | 1 | Xoff or special character detected |
| rts_edge | input | 1 | RTS transition |
| cts_edge | input | 1 | CTS transition |
| isr_rd | input | 1 | Interrupt status read strobe |
| ier_q | output | 8 | Stored enable register |
| sleep_en | output | 1 | Effective sleep enable |
| isr_code | output | 6 | Highest pending interrupt code |
| irq | output | 1 | Interrupt output |

## Verification
Some properties are checked on every cycle:
- Register writes honour the enhanced gate.
- Polled mode keeps the line quiet.
- Line and modem events surface on the next cycle.
- A character event cancels the timeout.
- Only legal codes appear.

Only the bench scenarios can show the full priority ladder, the read-to-clear rules per source, the exact tick count of the timeout, and the switch of transmit source in RS485 mode. Each of these depends on an ordered sequence of stimulus.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int CHAR_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [7:0] ier_wdata,
  input  logic       enh_en,
  input  logic       fifo_en,
  input  logic       rs485_auto,
  input  logic       rx_avail,
  input  logic       rx_at_trig,
  input  logic       rx_nonempty,
  input  logic       rx_char_evt,
  input  logic       bit_tick,
  input  logic       thr_empty,
  input  logic       tsr_empty,
  input  logic       thr_wr,
  input  logic       lsr_err_chg,
  input  logic       lsr_rd,
  input  logic [3:0] msr_chg,
  input  logic       msr_rd,
  input  logic       xoff_det,
  input  logic       rts_edge,
  input  logic       cts_edge,
  input  logic       isr_rd,
  output logic [7:0] ier_q,
  output logic       sleep_en,
  output logic [5:0] isr_code,
  output logic       irq
);
  localparam int TO_LIMIT = 4 * CHAR_BITS + 12;
  localparam int TW = $clog2(TO_LIMIT + 1);
  localparam logic [5:0] C_NONE = 6'h01, C_LINE = 6'h06, C_TOUT = 6'h0C,
                         C_RXRDY = 6'h04, C_TX = 6'h02, C_MODEM = 6'h00,
                         C_XOFF = 6'h10, C_FLOW = 6'h20;

  logic [7:0] en;
  logic tx_src, tx_src_q, tx_pend, line_pend, modem_pend, xoff_pend, rts_pend, cts_pend;
  logic [TW-1:0] to_cnt;
  logic to_run, to_hit, rx_ready, flow_act;

  assign en       = {ier_q[7:4] & {4{enh_en}}, ier_q[3:0]};
  assign sleep_en = en[4];
  assign tx_src   = rs485_auto ? tsr_empty : thr_empty;
  assign rx_ready = fifo_en ? rx_at_trig : rx_avail;
  assign to_run   = fifo_en & rx_nonempty & ~rx_at_trig;
  assign to_hit   = (to_cnt == TW'(TO_LIMIT));
  assign flow_act = (rts_pend & en[6]) | (cts_pend & en[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else if (ier_wr) ier_q <= {enh_en ? ier_wdata[7:4] : ier_q[7:4], ier_wdata[3:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_cnt <= '0;
    else if (!to_run || rx_char_evt) to_cnt <= '0;
    else if (bit_tick && !to_hit) to_cnt <= to_cnt + 1'b1;
  end

  always_comb begin
    if (line_pend && en[2])        isr_code = C_LINE;
    else if (to_hit && en[0])      isr_code = C_TOUT;
    else if (rx_ready && en[0])    isr_code = C_RXRDY;
    else if (tx_pend && en[1])     isr_code = C_TX;
    else if (modem_pend && en[3])  isr_code = C_MODEM;
    else if (xoff_pend && en[5])   isr_code = C_XOFF;
    else if (flow_act)             isr_code = C_FLOW;
    else                           isr_code = C_NONE;
  end

  assign irq = (isr_code != C_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_src_q   <= 1'b0;
      tx_pend    <= 1'b0;
      line_pend  <= 1'b0;
      modem_pend <= 1'b0;
      xoff_pend  <= 1'b0;
      rts_pend   <= 1'b0;
      cts_pend   <= 1'b0;
    end else begin
      tx_src_q   <= tx_src;
      tx_pend    <= (tx_src & ~tx_src_q) |
                    (tx_pend & tx_src & ~thr_wr & ~(isr_rd && isr_code == C_TX));
      line_pend  <= lsr_err_chg | (line_pend & ~lsr_rd);
      modem_pend <= (|msr_chg) | (modem_pend & ~msr_rd);
      xoff_pend  <= xoff_det | (xoff_pend & ~(isr_rd && isr_code == C_XOFF));
      rts_pend   <= rts_edge | (rts_pend & ~(isr_rd && isr_code == C_FLOW));
      cts_pend   <= cts_edge | (cts_pend & ~(isr_rd && isr_code == C_FLOW));
    end
  end
endmodule

module uart_irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic       enh_en,
  input logic       rx_char_evt,
  input logic       lsr_err_chg,
  input logic [3:0] msr_chg,
  input logic [7:0] ier_q,
  input logic [5:0] isr_code,
  input logic       irq
);
  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr && !enh_en |=> ier_q[7:4] == $past(ier_q[7:4]));
  a_r2_lower_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_q[3:0] == $past(ier_wdata[3:0]));
  a_r11_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[3:0] == 4'h0 && !enh_en) |-> !irq);
  a_r7_line_next: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_err_chg && ier_q[2] |=> isr_code == 6'h06);
  a_r8_modem_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|msr_chg) && ier_q[3] |=> irq);
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char_evt |=> isr_code != 6'h0C);
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    isr_code inside {6'h01, 6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20});
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
  .enh_en(enh_en), .rx_char_evt(rx_char_evt), .lsr_err_chg(lsr_err_chg),
  .msr_chg(msr_chg), .ier_q(ier_q), .isr_code(isr_code), .irq(irq)
);

// File: tb/uart_irq_prio_tb.sv
module uart_irq_prio_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_wr = 0, enh_en = 0, fifo_en = 0, rs485_auto = 0;
  logic [7:0] ier_wdata = 0;
  logic rx_avail = 0, rx_at_trig = 0, rx_nonempty = 0, rx_char_evt = 0, bit_tick = 0;
  logic thr_empty = 0, tsr_empty = 0, thr_wr = 0, lsr_err_chg = 0, lsr_rd = 0;
  logic [3:0] msr_chg = 0;
  logic msr_rd = 0, xoff_det = 0, rts_edge = 0, cts_edge = 0, isr_rd = 0;
  logic [7:0] ier_q;
  logic sleep_en, irq;
  logic [5:0] isr_code;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  uart_irq_prio dut_i (.*);

  typedef struct {
    logic [5:0] code;
    logic       chk_ier;
    logic [7:0] ier;
    logic       slp;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic exp_code(input logic [5:0] c, input string tag);
    exp_t e; e.code = c; e.chk_ier = 0; e.ier = 0; e.slp = 0; e.tag = tag; q.push_back(e);
  endtask

  task automatic exp_ier(input logic [7:0] v, input logic s, input logic [5:0] c, input string tag);
    exp_t e; e.code = c; e.chk_ier = 1; e.ier = v; e.slp = s; e.tag = tag; q.push_back(e);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wdata = v; ier_wr = 1; tick(); ier_wr = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (isr_code !== e.code || irq !== (e.code != 6'h01)) begin
          bad++;
          $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                   e.tag, isr_code, irq, e.code, e.code != 6'h01);
        end
        if (e.chk_ier) begin
          total++;
          if (ier_q !== e.ier || sleep_en !== e.slp) begin
            bad++;
            $display("FAIL %s: ier=%h sleep=%b expected ier=%h sleep=%b",
                     e.tag, ier_q, sleep_en, e.ier, e.slp);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    exp_ier(8'h00, 1'b0, 6'h01, "R1 reset");
    rst_n = 1; tick();
    exp_ier(8'h00, 1'b0, 6'h01, "R1 after release");
    tick();

    wr_ier(8'hF5);
    exp_ier(8'h05, 1'b0, 6'h01, "R2 upper blocked");
    tick();
    enh_en = 1; wr_ier(8'hF0);
    exp_ier(8'hF0, 1'b1, 6'h01, "R2 upper written");
    tick();
    enh_en = 0; tick();
    exp_ier(8'hF0, 1'b0, 6'h01, "R2 sleep gated");
    tick();

    xoff_det = 1; tick(); xoff_det = 0;
    exp_code(6'h01, "R3 xoff masked");
    tick();
    enh_en = 1; tick();
    exp_code(6'h10, "R3 xoff after enable");
    tick();
    isr_rd = 1; tick(); isr_rd = 0;
    exp_code(6'h01, "R9 xoff cleared");
    tick();
    rts_edge = 1; tick(); rts_edge = 0;
    exp_code(6'h20, "R9 rts edge");
    tick();
    isr_rd = 1; tick(); isr_rd = 0;
    cts_edge = 1; tick(); cts_edge = 0;
    exp_code(6'h20, "R9 cts edge");
    tick();
    isr_rd = 1; tick(); isr_rd = 0;
    exp_code(6'h01, "R9 flow cleared");
    tick();

    enh_en = 0; wr_ier(8'h00);
    fifo_en = 1; rx_at_trig = 1; lsr_err_chg = 1; msr_chg = 4'b0010; xoff_det = 1;
    tick(); lsr_err_chg = 0; msr_chg = 0; xoff_det = 0;
    exp_code(6'h01, "R11 polled");
    tick();
    rx_at_trig = 0; lsr_rd = 1; msr_rd = 1; tick(); lsr_rd = 0; msr_rd = 0;
    enh_en = 1; isr_rd = 1; tick(); isr_rd = 0; enh_en = 0;

    wr_ier(8'h01); fifo_en = 0; rx_avail = 1; tick();
    exp_code(6'h04, "R4 non-fifo data");
    tick();
    rx_avail = 0; tick();
    exp_code(6'h01, "R4 non-fifo gone");
    tick();
    fifo_en = 1; rx_avail = 1; tick();
    exp_code(6'h01, "R4 fifo below trigger");
    tick();
    rx_at_trig = 1; tick();
    exp_code(6'h04, "R4 fifo at trigger");
    tick();
    rx_at_trig = 0; rx_avail = 0; tick();
    exp_code(6'h01, "R4 fifo drained");
    tick();

    wr_ier(8'h02); thr_empty = 1; tick();
    exp_code(6'h02, "R6 thr empty");
    tick();
    isr_rd = 1; tick(); isr_rd = 0;
    exp_code(6'h01, "R6 cleared by status read");
    tick();
    thr_empty = 0; tick(); thr_empty = 1; tick();
    exp_code(6'h02, "R6 second empty");
    tick();
    thr_wr = 1; tick(); thr_wr = 0;
    exp_code(6'h01, "R6 cleared by write");
    tick();
    thr_empty = 0; rs485_auto = 1; tick(); thr_empty = 1; tick();
    exp_code(6'h01, "R6 rs485 ignores holding flag");
    tick();
    tsr_empty = 1; tick();
    exp_code(6'h02, "R6 rs485 full empty");
    tick();
    tsr_empty = 0; tick();
    exp_code(6'h01, "R6 source fell");
    rs485_auto = 0; thr_empty = 0; tick(); tick();

    wr_ier(8'h04); lsr_err_chg = 1; tick(); lsr_err_chg = 0;
    exp_code(6'h06, "R7 line");
    tick();
    isr_rd = 1; tick(); isr_rd = 0;
    exp_code(6'h06, "R7 held over status read");
    tick();
    lsr_rd = 1; tick(); lsr_rd = 0;
    exp_code(6'h01, "R7 cleared");
    tick();

    wr_ier(8'h08); msr_chg = 4'b0100; tick(); msr_chg = 0;
    exp_code(6'h00, "R8/R12 modem irq");
    tick();
    msr_rd = 1; tick(); msr_rd = 0;
    exp_code(6'h01, "R8 cleared");
    tick();

    wr_ier(8'h0F); rx_at_trig = 1; lsr_err_chg = 1; msr_chg = 4'b0001;
    tick(); lsr_err_chg = 0; msr_chg = 0;
    exp_code(6'h06, "R10 line first");
    tick();
    lsr_rd = 1; tick(); lsr_rd = 0;
    exp_code(6'h04, "R10 rx next");
    tick();
    rx_at_trig = 0; tick();
    exp_code(6'h00, "R10 modem kept");
    tick();
    msr_rd = 1; tick(); msr_rd = 0;
    exp_code(6'h01, "R10 all clear");
    tick();

    wr_ier(8'h01); rx_nonempty = 1; tick();
    bit_tick = 1; repeat (51) tick(); bit_tick = 0;
    exp_code(6'h01, "R5 one tick short");
    tick();
    bit_tick = 1; tick(); bit_tick = 0;
    exp_code(6'h0C, "R5 timeout");
    tick();
    rx_char_evt = 1; tick(); rx_char_evt = 0;
    exp_code(6'h01, "R5 restart");
    tick();
    rx_nonempty = 0; tick(); tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule